// File: doc/BRIEF.md
# Descriptor-Ring Receive DMA Channel

This block is the receive half of a ring-based DMA engine. Software prepares a ring of descriptors inside one 4096-byte aligned memory page. Each descriptor names an empty buffer and gives its size in bytes. Software then publishes the ring offset of the last descriptor it has posted. The channel reads each descriptor over a memory read port. It then moves bytes from a receive FIFO into the buffer over a byte-wide memory write port. A frame longer than one buffer continues into the next descriptor. The channel never writes descriptors back to memory.

The first buffer of a frame is filled starting at a programmable offset of 0 to 127 bytes. This leaves headroom in front of the packet. Continuation buffers are filled from their first byte. After a descriptor marked end-of-table, the channel returns to the start of the ring. When the channel catches up with software, it waits in an idle state. If the FIFO fills up while the channel is idle, the channel stops and reports a FIFO overflow. That error code is separate from the protocol and bus error codes. When the direct-FIFO mode select is set, the channel does not touch the ring at all.

Top module: `rxdma_chan`

## Requirements
- R1: After reset, and whenever `cfg_enable` is low, `status` reads 0 and `rd_req`, `wr_req` and `fifo_ready` are low. Dropping `cfg_enable` also clears a latched error and returns the ring offset to 0.
- R2: While the current ring offset (`status[11:0]`) equals `last_idx`, the channel reports state 2 (idle wait) in `status[15:12]` and issues no descriptor read.
- R3: A descriptor is read as one 64-bit word at address `{ring_page, offset}`, with the low 3 address bits zero. The low half is the control word: byte count in bits [12:0], end-of-table flag in bit 28. The high half is the buffer address. While the channel is working on a fetched descriptor, `status[31:20]` shows that descriptor's ring offset and `status[15:12]` reads 1 (active).
- R4: The first buffer of a frame receives its bytes at consecutive addresses starting at buffer address plus `cfg_offset`. It holds at most byte count minus `cfg_offset` bytes.
- R5: If a frame still has bytes when a buffer is full, the channel fetches the next descriptor. It continues the frame in that buffer starting at offset 0, and that buffer holds up to its full byte count.
- R6: When a frame ends (`fifo_last`) or a buffer fills, the ring offset advances by 8. After an end-of-table descriptor, the ring offset returns to 0.
- R7: In idle wait, an asserted `fifo_full` sets error code 2 (`status[19:16]`) and moves the channel to state 3 (stopped).
- R8: A descriptor whose byte count does not exceed its start offset sets error code 1 and stops the channel. The start offset is `cfg_offset` for the first buffer of a frame and 0 for a continuation buffer.
- R9: A read reply with `rd_err` sets error code 4. A write acknowledge with `wr_err` sets error code 3. In both cases the channel stops and issues no further requests until `cfg_enable` goes low.
- R10: While `cfg_pio` is set, the channel ignores the ring. It makes no descriptor reads, keeps `fifo_ready` low and reports `status` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_offset | input | 7 | Start offset inside the first buffer of a frame |
| cfg_pio | input | 1 | Direct-FIFO mode select; the ring is ignored while set |
| ring_page | input | 20 | Address bits [31:12] of the descriptor ring |
| last_idx | input | 12 | Ring offset of the last descriptor posted by software |
| rd_req | output | 1 | Descriptor read request, held until acknowledged |
| rd_addr | output | 32 | Descriptor read address |
| rd_ack | input | 1 | Read reply valid |
| rd_err | input | 1 | Bus error on the read reply |
| rd_data | input | 64 | Descriptor: {buffer address, control word} |
| fifo_valid | input | 1 | Receive FIFO has a byte |
| fifo_data | input | 8 | Receive FIFO byte |
| fifo_last | input | 1 | Byte is the last of its frame |
| fifo_full | input | 1 | Receive FIFO is full |
| fifo_ready | output | 1 | Channel accepts a byte this cycle |
| wr_req | output | 1 | Buffer byte write request, held until acknowledged |
| wr_addr | output | 32 | Buffer byte address |
| wr_data | output | 8 | Buffer byte |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Bus error on the write |
| status | output | 32 | {active descriptor, error, state, current descriptor} |

## Verification
The bench sends a short frame that fits into one offset buffer. This checks the offset arithmetic and the exact byte addresses. It then sends a frame that spills from a small offset buffer into a second buffer, which separates the first-buffer capacity rule from the continuation rule that starts at offset 0. Two one-byte frames across an end-of-table descriptor show the wrap back to offset 0, as opposed to a plain advance by 8. Separate runs inject an undersized descriptor, a read bus error, a write bus error and a full FIFO during idle, and each run checks for its own error code. A final run with direct-FIFO mode set confirms that no descriptor read is issued and that releasing the mode starts a fetch.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [2:0] {
    S_DIS, S_CHECK, S_IDLE, S_FETCH, S_FILL, S_WRITE, S_STOP
  } rx_st_e;

  localparam logic [3:0] ERR_NONE = 4'd0;
  localparam logic [3:0] ERR_DESC = 4'd1;
  localparam logic [3:0] ERR_OVF  = 4'd2;
  localparam logic [3:0] ERR_WBUS = 4'd3;
  localparam logic [3:0] ERR_RBUS = 4'd4;

  localparam logic [3:0] CODE_DIS  = 4'd0;
  localparam logic [3:0] CODE_ACT  = 4'd1;
  localparam logic [3:0] CODE_IDLE = 4'd2;
  localparam logic [3:0] CODE_STOP = 4'd3;
endpackage

// File: rtl/rxdma_desc_dec.sv
// Splits a fetched descriptor and works out where filling starts and how
// many bytes fit.
module rxdma_desc_dec #(
  parameter int AW      = 32,
  parameter int BCW     = 13,
  parameter int OFSW    = 7,
  parameter int EOT_BIT = 28
) (
  input  logic [2*AW-1:0] desc,
  input  logic            first_buf,
  input  logic [OFSW-1:0] offset,
  output logic [AW-1:0]   buf_addr,
  output logic            eot,
  output logic [OFSW-1:0] start,
  output logic [BCW-1:0]  cap,
  output logic            bad
);
  logic [BCW-1:0] count;
  logic [BCW-1:0] start_w;

  always_comb begin
    count    = desc[BCW-1:0];
    eot      = desc[EOT_BIT];
    buf_addr = desc[2*AW-1:AW];
    start    = first_buf ? offset : '0;
    start_w  = {{(BCW-OFSW){1'b0}}, start};
    bad      = (count <= start_w);
    cap      = count - start_w;
  end
endmodule

// File: rtl/rxdma_fsm.sv
// Sequencing of the channel: ring walk, descriptor fetch, byte fill, errors.
module rxdma_fsm
  import rxdma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 12,
  parameter int BCW  = 13,
  parameter int OFSW = 7,
  parameter int DW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_pio,
  input  logic [AW-IDXW-1:0] ring_page,
  input  logic [IDXW-1:0]   last_idx,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ack,
  input  logic              rd_err,
  output logic              first_buf,
  input  logic [AW-1:0]     dec_buf,
  input  logic              dec_eot,
  input  logic [OFSW-1:0]   dec_start,
  input  logic [BCW-1:0]    dec_cap,
  input  logic              dec_bad,
  input  logic              fifo_valid,
  input  logic [DW-1:0]     fifo_data,
  input  logic              fifo_last,
  input  logic              fifo_full,
  output logic              fifo_ready,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data,
  input  logic              wr_ack,
  input  logic              wr_err,
  output rx_st_e            st,
  output logic [IDXW-1:0]   cur_idx,
  output logic [IDXW-1:0]   act_idx,
  output logic [3:0]        err
);
  localparam logic [IDXW-1:0] STEP = IDXW'(8);

  rx_st_e          st_q, st_n;
  logic [IDXW-1:0] cd_q, cd_n, ad_q, ad_n;
  logic [3:0]      err_q, err_n;
  logic            sof_q, sof_n;
  logic [BCW-1:0]  pos_q, pos_n;
  logic [AW-1:0]   rda_q, rda_n;
  logic            ld_addr, ld_desc, ld_byte;

  logic [AW-1:0]   buf_q;
  logic [OFSW-1:0] start_q;
  logic [BCW-1:0]  cap_q;
  logic            eot_q;
  logic [AW-1:0]   wa_q;
  logic [DW-1:0]   wd_q;
  logic            last_q;
  logic [BCW-1:0]  pos_inc;

  assign pos_inc = pos_q + BCW'(1);

  always_comb begin
    st_n    = st_q;
    cd_n    = cd_q;
    ad_n    = ad_q;
    err_n   = err_q;
    sof_n   = sof_q;
    pos_n   = pos_q;
    rda_n   = rda_q;
    ld_addr = 1'b0;
    ld_desc = 1'b0;
    ld_byte = 1'b0;
    if (!cfg_enable || cfg_pio) begin
      st_n  = S_DIS;
      cd_n  = '0;
      ad_n  = '0;
      err_n = ERR_NONE;
      sof_n = 1'b1;
    end else begin
      case (st_q)
        S_DIS:   st_n = S_CHECK;
        S_CHECK: begin
          if (cd_q == last_idx) begin
            st_n = S_IDLE;
          end else begin
            ld_addr = 1'b1;
            rda_n   = {ring_page, cd_q};
            st_n    = S_FETCH;
          end
        end
        S_IDLE: begin
          if (fifo_full) begin
            err_n = ERR_OVF;
            st_n  = S_STOP;
          end else if (cd_q != last_idx) begin
            st_n = S_CHECK;
          end
        end
        S_FETCH: begin
          if (rd_ack) begin
            if (rd_err) begin
              err_n = ERR_RBUS;
              st_n  = S_STOP;
            end else if (dec_bad) begin
              ad_n  = cd_q;
              err_n = ERR_DESC;
              st_n  = S_STOP;
            end else begin
              ad_n    = cd_q;
              ld_desc = 1'b1;
              pos_n   = '0;
              st_n    = S_FILL;
            end
          end
        end
        S_FILL: begin
          if (fifo_valid) begin
            ld_byte = 1'b1;
            st_n    = S_WRITE;
          end
        end
        S_WRITE: begin
          if (wr_ack) begin
            if (wr_err) begin
              err_n = ERR_WBUS;
              st_n  = S_STOP;
            end else begin
              pos_n = pos_inc;
              if (last_q || (pos_inc == cap_q)) begin
                cd_n  = eot_q ? '0 : (cd_q + STEP);
                sof_n = last_q;
                st_n  = S_CHECK;
              end else begin
                st_n = S_FILL;
              end
            end
          end
        end
        default: st_n = S_STOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_DIS;
      cd_q  <= '0;
      ad_q  <= '0;
      err_q <= ERR_NONE;
      sof_q <= 1'b1;
      pos_q <= '0;
    end else begin
      st_q  <= st_n;
      cd_q  <= cd_n;
      ad_q  <= ad_n;
      err_q <= err_n;
      sof_q <= sof_n;
      pos_q <= pos_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rda_q   <= '0;
      buf_q   <= '0;
      start_q <= '0;
      cap_q   <= '0;
      eot_q   <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
      last_q  <= 1'b0;
    end else begin
      if (ld_addr) rda_q <= rda_n;
      if (ld_desc) begin
        buf_q   <= dec_buf;
        start_q <= dec_start;
        cap_q   <= dec_cap;
        eot_q   <= dec_eot;
      end
      if (ld_byte) begin
        wa_q   <= buf_q + AW'(start_q) + AW'(pos_q);
        wd_q   <= fifo_data;
        last_q <= fifo_last;
      end
    end
  end

  assign rd_req     = (st_q == S_FETCH);
  assign rd_addr    = rda_q;
  assign fifo_ready = (st_q == S_FILL);
  assign wr_req     = (st_q == S_WRITE);
  assign wr_addr    = wa_q;
  assign wr_data    = wd_q;
  assign first_buf  = sof_q;
  assign st         = st_q;
  assign cur_idx    = cd_q;
  assign act_idx    = ad_q;
  assign err        = err_q;
endmodule

// File: rtl/rxdma_stat_pack.sv
// Builds the status word from the sequencer state.
module rxdma_stat_pack
  import rxdma_pkg::*;
#(
  parameter int IDXW = 12,
  localparam int SW  = 2*IDXW + 8
) (
  input  rx_st_e          st,
  input  logic [IDXW-1:0] cur_idx,
  input  logic [IDXW-1:0] act_idx,
  input  logic [3:0]      err,
  output logic [SW-1:0]   status
);
  logic [3:0] code;

  always_comb begin
    case (st)
      S_DIS:   code = CODE_DIS;
      S_IDLE:  code = CODE_IDLE;
      S_STOP:  code = CODE_STOP;
      default: code = CODE_ACT;
    endcase
    status = {act_idx, err, code, cur_idx};
  end
endmodule

// File: rtl/rxdma_chan.sv
module rxdma_chan
  import rxdma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 12,
  parameter int BCW  = 13,
  parameter int OFSW = 7,
  parameter int DW   = 8,
  localparam int PW  = AW - IDXW,
  localparam int SW  = 2*IDXW + 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_enable,
  input  logic [OFSW-1:0] cfg_offset,
  input  logic            cfg_pio,
  input  logic [PW-1:0]   ring_page,
  input  logic [IDXW-1:0] last_idx,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_ack,
  input  logic            rd_err,
  input  logic [2*AW-1:0] rd_data,
  input  logic            fifo_valid,
  input  logic [DW-1:0]   fifo_data,
  input  logic            fifo_last,
  input  logic            fifo_full,
  output logic            fifo_ready,
  output logic            wr_req,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  input  logic            wr_ack,
  input  logic            wr_err,
  output logic [SW-1:0]   status
);
  logic [1:0]      rst_sync;
  logic            rst_int_n;
  logic            first_buf;
  logic [AW-1:0]   dec_buf;
  logic            dec_eot;
  logic [OFSW-1:0] dec_start;
  logic [BCW-1:0]  dec_cap;
  logic            dec_bad;
  rx_st_e          st;
  logic [IDXW-1:0] cur_idx, act_idx;
  logic [3:0]      err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  rxdma_desc_dec #(.AW(AW), .BCW(BCW), .OFSW(OFSW)) dec_i (
    .desc(rd_data), .first_buf(first_buf), .offset(cfg_offset),
    .buf_addr(dec_buf), .eot(dec_eot), .start(dec_start),
    .cap(dec_cap), .bad(dec_bad)
  );

  rxdma_fsm #(.AW(AW), .IDXW(IDXW), .BCW(BCW), .OFSW(OFSW), .DW(DW)) fsm_i (
    .clk(clk), .rst_n(rst_int_n), .cfg_enable(cfg_enable), .cfg_pio(cfg_pio),
    .ring_page(ring_page), .last_idx(last_idx),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_err(rd_err),
    .first_buf(first_buf), .dec_buf(dec_buf), .dec_eot(dec_eot),
    .dec_start(dec_start), .dec_cap(dec_cap), .dec_bad(dec_bad),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .fifo_full(fifo_full), .fifo_ready(fifo_ready),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_err(wr_err),
    .st(st), .cur_idx(cur_idx), .act_idx(act_idx), .err(err)
  );

  rxdma_stat_pack #(.IDXW(IDXW)) stat_i (
    .st(st), .cur_idx(cur_idx), .act_idx(act_idx), .err(err), .status(status)
  );
endmodule

// File: rtl/rxdma_chan_chk.sv
module rxdma_chan_chk #(
  parameter int AW   = 32,
  parameter int IDXW = 12,
  localparam int PW  = AW - IDXW,
  localparam int SW  = 2*IDXW + 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_enable,
  input logic            cfg_pio,
  input logic [PW-1:0]   ring_page,
  input logic            rd_req,
  input logic [AW-1:0]   rd_addr,
  input logic            rd_ack,
  input logic            fifo_full,
  input logic            fifo_ready,
  input logic            wr_req,
  input logic [SW-1:0]   status
);
  logic [3:0] st_code, err_code;
  assign st_code  = status[IDXW+3:IDXW];
  assign err_code = status[IDXW+7:IDXW+4];

  p_pio_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pio |=> (!rd_req && !fifo_ready && !wr_req));

  p_disabled_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (status == '0));

  p_idle_no_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 4'd2) |-> !rd_req);

  p_fetch_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[AW-1:IDXW] == ring_page && rd_addr[2:0] == 3'b000));

  p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && cfg_enable && !cfg_pio) |=> (rd_req && $stable(rd_addr)));

  p_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 4'd2 && fifo_full && cfg_enable && !cfg_pio) |=>
      (err_code == 4'd2 && st_code == 4'd3));

  p_err_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 4'd0) |-> (st_code == 4'd3 && !rd_req && !wr_req));
endmodule

bind rxdma_chan rxdma_chan_chk #(.AW(AW), .IDXW(IDXW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_pio(cfg_pio),
  .ring_page(ring_page), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
  .fifo_full(fifo_full), .fifo_ready(fifo_ready), .wr_req(wr_req),
  .status(status)
);

// File: tb/rxdma_chan_tb_top.sv
`timescale 1ns/1ps
module rxdma_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [6:0]  cfg_offset = '0;
  logic        cfg_pio = 1'b0;
  logic [19:0] ring_page = 20'h00010;
  logic [11:0] last_idx = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic        rd_err = 1'b0;
  logic [63:0] rd_data = '0;
  logic        fifo_valid = 1'b0;
  logic [7:0]  fifo_data = '0;
  logic        fifo_last = 1'b0;
  logic        fifo_full = 1'b0;
  logic        fifo_ready;
  logic        wr_req;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_ack = 1'b0;
  logic        wr_err = 1'b0;
  logic [31:0] status;

  always #5 clk = ~clk;

  rxdma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_offset(cfg_offset),
    .cfg_pio(cfg_pio), .ring_page(ring_page), .last_idx(last_idx),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_err(rd_err),
    .rd_data(rd_data), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_last(fifo_last), .fifo_full(fifo_full), .fifo_ready(fifo_ready),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .wr_err(wr_err), .status(status)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int fetches = 0;
  int nwr = 0;
  logic [31:0] wlog_a [0:63];
  logic [7:0]  wlog_d [0:63];
  logic [31:0] d_ctrl [0:15];
  logic [31:0] d_buf  [0:15];
  logic        inj_rd = 1'b0;
  logic        inj_wr = 1'b0;

  // memory model: one-cycle replies, byte write log
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_ack <= rd_req && !rd_ack;
    rd_err <= inj_rd;
    rd_data <= {d_buf[rd_addr[6:3]], d_ctrl[rd_addr[6:3]]};
    wr_ack <= wr_req && !wr_ack;
    wr_err <= inj_wr;
    if (rd_req && rd_ack) fetches <= fetches + 1;
    if (wr_req && wr_ack && nwr < 64) begin
      wlog_a[nwr] <= wr_addr;
      wlog_d[nwr] <= wr_data;
      nwr <= nwr + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_code(input logic [3:0] code);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (status[15:12] == code) break;
    end
  endtask

  task automatic restart(input logic [6:0] ofs, input logic [11:0] last);
    cfg_enable = 1'b0;
    repeat (3) @(negedge clk);
    nwr = 0;
    cfg_offset = ofs;
    last_idx = last;
    cfg_enable = 1'b1;
  endtask

  task automatic push(input logic [7:0] d, input logic lst);
    fifo_valid = 1'b1;
    fifo_data = d;
    fifo_last = lst;
    for (int i = 0; i < 300; i++) begin
      if (fifo_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    fifo_valid = 1'b0;
    fifo_last = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset status", status, 32'h0);
    check("R1 reset requests", {31'd0, rd_req | wr_req | fifo_ready}, 32'd0);
  endtask

  task automatic t_idle;
    restart(7'd0, 12'd0);
    repeat (10) @(negedge clk);
    check("R2 idle state", {28'd0, status[15:12]}, 32'd2);
    check("R2 no fetch", fetches, 0);
  endtask

  task automatic t_single;
    d_ctrl[0] = 32'd64;
    d_buf[0] = 32'h2000_0000;
    restart(7'd5, 12'd8);
    for (int i = 0; i < 4; i++) push(8'hA0 + 8'(i), i == 3);
    wait_code(4'd2);
    check("R4 write count", nwr, 4);
    for (int i = 0; i < 4; i++) begin
      check("R4 byte addr", wlog_a[i], 32'h2000_0005 + 32'(i));
      check("R4 byte data", {24'd0, wlog_d[i]}, {24'd0, 8'hA0 + 8'(i)});
    end
    check("R6 advance by 8", {20'd0, status[11:0]}, 32'd8);
    check("R3 active desc", {20'd0, status[31:20]}, 32'd0);
  endtask

  task automatic t_spill;
    d_ctrl[0] = 32'd16; d_buf[0] = 32'h3000_0000;
    d_ctrl[1] = 32'd8;  d_buf[1] = 32'h3100_0000;
    d_ctrl[2] = 32'd64; d_buf[2] = 32'h3200_0000;
    restart(7'd10, 12'd24);
    for (int i = 0; i < 10; i++) push(8'h10 + 8'(i), i == 9);
    repeat (8) @(negedge clk);
    check("R4 spill count", nwr, 10);
    for (int i = 0; i < 6; i++)
      check("R4 first buf addr", wlog_a[i], 32'h3000_000A + 32'(i));
    for (int i = 0; i < 4; i++)
      check("R5 continuation addr", wlog_a[6+i], 32'h3100_0000 + 32'(i));
    check("R5 data order", {24'd0, wlog_d[9]}, 32'h19);
    check("R3 next active", {status[31:20], 4'd0, status[15:12], status[11:0]},
          {12'd16, 4'd0, 4'd1, 12'd16});
  endtask

  task automatic t_wrap;
    d_ctrl[0] = 32'd32;               d_buf[0] = 32'h4000_0000;
    d_ctrl[1] = 32'd32 | (32'd1 << 28); d_buf[1] = 32'h4100_0000;
    restart(7'd0, 12'd16);
    push(8'h55, 1'b1);
    push(8'h66, 1'b1);
    repeat (8) @(negedge clk);
    check("R6 eot frame addr", wlog_a[1], 32'h4100_0000);
    check("R6 wrap to 0", {20'd0, status[11:0]}, 32'd0);
    check("R3 refetch ring base", {20'd0, status[31:20]}, 32'd0);
    check("R3 active after wrap", {28'd0, status[15:12]}, 32'd1);
  endtask

  task automatic t_overflow;
    restart(7'd0, 12'd0);
    wait_code(4'd2);
    fifo_full = 1'b1;
    @(negedge clk);
    fifo_full = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 overflow", {24'd0, status[19:12]}, 32'h23);
    cfg_enable = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 disable clears", status, 32'h0);
  endtask

  task automatic t_proto;
    d_ctrl[0] = 32'd20; d_buf[0] = 32'h5000_0000;
    restart(7'd20, 12'd8);
    wait_code(4'd3);
    check("R8 protocol error", {24'd0, status[19:12]}, 32'h13);
    d_ctrl[0] = 32'd4; d_ctrl[1] = 32'd0;
    restart(7'd0, 12'd16);
    for (int i = 0; i < 4; i++) push(8'h70 + 8'(i), 1'b0);
    wait_code(4'd3);
    check("R8 empty continuation", {status[31:20], 4'd0, status[19:12]},
          {12'd8, 4'd0, 8'h13});
  endtask

  task automatic t_bus;
    d_ctrl[0] = 32'd64; d_buf[0] = 32'h6000_0000;
    inj_rd = 1'b1;
    restart(7'd0, 12'd8);
    wait_code(4'd3);
    check("R9 read bus error", {24'd0, status[19:12]}, 32'h43);
    inj_rd = 1'b0;
    inj_wr = 1'b1;
    restart(7'd0, 12'd8);
    push(8'h99, 1'b1);
    wait_code(4'd3);
    check("R9 write bus error", {24'd0, status[19:12]}, 32'h33);
    repeat (5) @(negedge clk);
    check("R9 stays stopped", {28'd0, status[15:12]}, 32'd3);
    inj_wr = 1'b0;
  endtask

  task automatic t_pio;
    int f0;
    d_ctrl[0] = 32'd64; d_buf[0] = 32'h7000_0000;
    cfg_enable = 1'b0;
    repeat (3) @(negedge clk);
    cfg_pio = 1'b1;
    last_idx = 12'd8;
    cfg_enable = 1'b1;
    f0 = fetches;
    repeat (20) @(negedge clk);
    check("R10 no fetch in pio", fetches - f0, 0);
    check("R10 status zero", status, 32'h0);
    check("R10 ready low", {31'd0, fifo_ready}, 32'd0);
    cfg_pio = 1'b0;
    repeat (8) @(negedge clk);
    check("R10 release fetches", fetches - f0, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      d_ctrl[i] = 32'd64;
      d_buf[i] = 32'h0100_0000 * 32'(i + 1);
    end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_idle;
    t_single;
    t_spill;
    t_wrap;
    t_overflow;
    t_proto;
    t_bus;
    t_pio;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule